// File: doc/BRIEF.md
# Per-Pin Edge Interrupt Engine with Persistence Filter

This block turns a bank of general-purpose input levels into a pending-interrupt status word and a single open-drain, active-low interrupt request. Each pin is qualified by its direction and interrupt-enable bits. A pair of edge-select bits picks rising-only, falling-only or either-edge detection. A per-pin persistence filter can require a new level to hold for a parameterised number of clock cycles before it counts as an edge.

The surrounding register block supplies the configuration bits. It also pulses a per-byte-lane strobe whenever software reads the pin-state register of that lane. A strobe clears the pending bits of its lane and records the debounced levels software has just seen. In the either-edge mode with both edge bits clear and the filter off, a pending bit also withdraws itself once the pin settles back to that recorded level. The block exports the debounced level word that feeds the state register's read path.

Top module: `gpio_irq_engine`

## Requirements
- R1: While `rst` is high at a clock edge, `irq_status` becomes 0, `irq_drive_low` becomes 0, and `deb_level` loads `pin_lvl`.
- R2: A pin with `dir_in`=0 (output) or `irq_en`=0 never has its `irq_status` bit set, and its bit is cleared at the next edge once it becomes inactive.
- R3: When `rise_en` and `fall_en` of a pin are equal (both 0 or both 1), a change of the debounced level in either direction sets its status bit.
- R4: `rise_en`=1 with `fall_en`=0 sets status only on a 0-to-1 debounced change; `fall_en`=1 with `rise_en`=0 only on a 1-to-0 change.
- R5: With `filt_en`=1, the debounced level adopts a new pin value only after that value has been sampled on FILT_CYCLES consecutive clock edges, so shorter pulses produce no edge and no status.
- R6: With `filt_en`=0, a pin value sampled at edge k appears on `deb_level` after edge k+1, and the resulting status bit is set after that same edge k+1.
- R7: A high `rd_strobe[l]` at an edge clears status bits [l*LANE_W +: LANE_W] (unless a new edge sets one) and records the current `deb_level` of that lane. Other lanes are untouched.
- R8: For a pin with `rise_en`=0, `fall_en`=0 and `filt_en`=0, a set status bit clears at the first edge with no new qualified change where `deb_level` equals the level recorded at the last read strobe (or at reset).
- R9: If a qualified edge and a read strobe for the same pin's lane fall on the same clock edge, the status bit ends up set.
- R10: `irq_drive_low` is 1 exactly when at least one `irq_status` bit is 1; both are updated at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | NPINS | Synchronised pin levels |
| dir_in | input | NPINS | 1 = pin is an input, 0 = output |
| irq_en | input | NPINS | Per-pin interrupt enable |
| rise_en | input | NPINS | Per-pin rising-edge select |
| fall_en | input | NPINS | Per-pin falling-edge select |
| filt_en | input | NPINS | Per-pin persistence filter enable |
| rd_strobe | input | NPINS/LANE_W | One-cycle pulse per lane when the state register of that lane is read |
| irq_status | output | NPINS | Pending interrupt bits |
| deb_level | output | NPINS | Debounced pin levels for the state read path |
| irq_drive_low | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
A new qualified edge and a state-read strobe for the same lane can land on the same clock edge. That collision decides whether an event is lost. The bench provokes it directly: it changes a pin and raises the strobe one cycle later, which is the edge where the change reaches the status logic. It then requires the bit to remain set. The same collision happens many times at random in a long mixed run. There the behavioural model, which applies the set-before-clear rule, is compared with the outputs on every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    EDGE_ANY  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2
  } edge_sel_e;

  // equal selects mean both directions count
  function automatic edge_sel_e edge_sel(input logic r, input logic f);
    if (r == f)  return EDGE_ANY;
    else if (r)  return EDGE_RISE;
    else         return EDGE_FALL;
  endfunction

  function automatic logic edge_hit(input edge_sel_e m, input logic now_v, input logic was_v);
    case (m)
      EDGE_RISE: return now_v & ~was_v;
      EDGE_FALL: return ~now_v & was_v;
      default:   return now_v ^ was_v;
    endcase
  endfunction

endpackage

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
  parameter int HOLD_CYCLES = 54
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic filt_on,
  output logic level
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_W = CW'(HOLD_CYCLES);
  localparam logic [CW-1:0] ONE_W  = CW'(1);

  logic          raw_q;
  logic [CW-1:0] run;
  logic [CW-1:0] run_nxt;
  logic [CW-1:0] thresh;

  // run = number of consecutive edges the current raw value has been sampled
  always_comb begin
    if (raw != raw_q)        run_nxt = ONE_W;
    else if (run == HOLD_W)  run_nxt = run;
    else                     run_nxt = run + ONE_W;
    thresh = filt_on ? HOLD_W : ONE_W;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= raw;
      run   <= HOLD_W;
      level <= raw;
    end else begin
      raw_q <= raw;
      run   <= run_nxt;
      if (run_nxt >= thresh) level <= raw;
    end
  end

endmodule

// File: rtl/irq_lane.sv
module irq_lane
  import gpio_irq_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] raw_lvl,
  input  logic [LANE_W-1:0] flt_lvl,
  input  logic [LANE_W-1:0] active,
  input  logic [LANE_W-1:0] rise_en,
  input  logic [LANE_W-1:0] fall_en,
  input  logic [LANE_W-1:0] filt_en,
  input  logic              rd,
  output logic [LANE_W-1:0] status,
  output logic [LANE_W-1:0] deb,
  output logic              pend_nxt
);
  logic [LANE_W-1:0] cap;
  logic [LANE_W-1:0] st_nxt;
  logic [LANE_W-1:0] hit;
  logic [LANE_W-1:0] self_clr;

  for (genvar b = 0; b < LANE_W; b++) begin : g_bit
    assign hit[b]      = edge_hit(edge_sel(rise_en[b], fall_en[b]), flt_lvl[b], deb[b]);
    assign self_clr[b] = ~filt_en[b] & ~rise_en[b] & ~fall_en[b] & (deb[b] == cap[b]);
    // priority: inactive pin, new edge, read clear, return-to-captured clear
    assign st_nxt[b]   = !active[b]  ? 1'b0 :
                         hit[b]      ? 1'b1 :
                         rd          ? 1'b0 :
                         self_clr[b] ? 1'b0 : status[b];
  end

  assign pend_nxt = |st_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      deb    <= raw_lvl;
      cap    <= raw_lvl;
    end else begin
      status <= st_nxt;
      deb    <= flt_lvl;
      if (rd) cap <= deb;
    end
  end

endmodule

// File: rtl/gpio_irq_engine.sv
module gpio_irq_engine #(
  parameter int NPINS       = 16,
  parameter int LANE_W      = 8,
  parameter int FILT_CYCLES = 54
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPINS-1:0]         pin_lvl,
  input  logic [NPINS-1:0]         dir_in,
  input  logic [NPINS-1:0]         irq_en,
  input  logic [NPINS-1:0]         rise_en,
  input  logic [NPINS-1:0]         fall_en,
  input  logic [NPINS-1:0]         filt_en,
  input  logic [NPINS/LANE_W-1:0]  rd_strobe,
  output logic [NPINS-1:0]         irq_status,
  output logic [NPINS-1:0]         deb_level,
  output logic                     irq_drive_low
);
  localparam int NLANES = NPINS / LANE_W;

  logic [NPINS-1:0]  flt;
  logic [NPINS-1:0]  active;
  logic [NLANES-1:0] lane_pend;

  assign active = dir_in & irq_en;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_deglitch #(.HOLD_CYCLES(FILT_CYCLES)) u_dg (
      .clk     (clk),
      .rst     (rst),
      .raw     (pin_lvl[p]),
      .filt_on (filt_en[p]),
      .level   (flt[p])
    );
  end

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    irq_lane #(.LANE_W(LANE_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .raw_lvl  (pin_lvl[l*LANE_W +: LANE_W]),
      .flt_lvl  (flt[l*LANE_W +: LANE_W]),
      .active   (active[l*LANE_W +: LANE_W]),
      .rise_en  (rise_en[l*LANE_W +: LANE_W]),
      .fall_en  (fall_en[l*LANE_W +: LANE_W]),
      .filt_en  (filt_en[l*LANE_W +: LANE_W]),
      .rd       (rd_strobe[l]),
      .status   (irq_status[l*LANE_W +: LANE_W]),
      .deb      (deb_level[l*LANE_W +: LANE_W]),
      .pend_nxt (lane_pend[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_drive_low <= 1'b0;
    else     irq_drive_low <= |lane_pend;
  end

endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker #(
  parameter int NPINS       = 16,
  parameter int LANE_W      = 8,
  parameter int FILT_CYCLES = 54
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NPINS-1:0]        pin_lvl,
  input logic [NPINS-1:0]        dir_in,
  input logic [NPINS-1:0]        irq_en,
  input logic [NPINS-1:0]        filt_en,
  input logic [NPINS/LANE_W-1:0] rd_strobe,
  input logic [NPINS-1:0]        irq_status,
  input logic [NPINS-1:0]        deb_level,
  input logic                    irq_drive_low
);
  logic [NPINS-1:0] deb_prev;
  logic [NPINS-1:0] deb_chg;

  always_ff @(posedge clk) deb_prev <= deb_level;
  assign deb_chg = deb_level ^ deb_prev;

  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_status & ~$past(dir_in & irq_en)) == '0)); // R2

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_drive_low == (irq_status != '0)); // R10

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_strobe[0] |=> ((irq_status[LANE_W-1:0] & ~deb_chg[LANE_W-1:0]) == '0)); // R7

  if (FILT_CYCLES >= 2) begin : g_filt
    for (genvar i = 0; i < NPINS; i++) begin : g_p
      AST_FILT_STEADY: assert property (@(posedge clk) disable iff (rst)
        (filt_en[i] && (pin_lvl[i] != $past(pin_lvl[i]))) |=> ##1 $stable(deb_level[i])); // R5
    end
  end

endmodule

bind gpio_irq_engine gpio_irq_checker #(
  .NPINS(NPINS), .LANE_W(LANE_W), .FILT_CYCLES(FILT_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .dir_in(dir_in), .irq_en(irq_en),
  .filt_en(filt_en), .rd_strobe(rd_strobe), .irq_status(irq_status),
  .deb_level(deb_level), .irq_drive_low(irq_drive_low)
);

// File: tb/gpio_irq_engine_test.sv
`timescale 1ns/1ps
module gpio_irq_engine_test;
  localparam int N  = 16;
  localparam int LW = 8;
  localparam int NL = N / LW;
  localparam int FC = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]  pin = '0, dir = '0, ien = '0, ren = '0, fen = '0, flt_on = '1;
  logic [NL-1:0] rd = '0;
  logic [N-1:0]  st, deb;
  logic          irq;

  gpio_irq_engine #(.NPINS(N), .LANE_W(LW), .FILT_CYCLES(FC)) uut (
    .clk(clk), .rst(rst), .pin_lvl(pin), .dir_in(dir), .irq_en(ien),
    .rise_en(ren), .fall_en(fen), .filt_en(flt_on), .rd_strobe(rd),
    .irq_status(st), .deb_level(deb), .irq_drive_low(irq)
  );

  always #2.5 clk = ~clk;

  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [N-1:0] m_rawq, m_flt, m_lvl, m_cap, m_st;
  logic         m_irq;
  int           m_run [N];

  always @(posedge clk) begin
    logic [N-1:0] n_st;
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        m_rawq[i] = pin[i]; m_run[i] = FC; m_flt[i] = pin[i];
        m_lvl[i]  = pin[i]; m_cap[i] = pin[i]; n_st[i] = 1'b0;
      end else begin
        int  thr, nr;
        logic hit, act, ac;
        thr = flt_on[i] ? FC : 1;
        if (pin[i] != m_rawq[i]) nr = 1;
        else nr = (m_run[i] >= FC) ? FC : m_run[i] + 1;
        if (ren[i] && !fen[i])      hit = m_flt[i] && !m_lvl[i];
        else if (fen[i] && !ren[i]) hit = !m_flt[i] && m_lvl[i];
        else                        hit = m_flt[i] != m_lvl[i];
        act = dir[i] && ien[i];
        ac  = !flt_on[i] && !ren[i] && !fen[i] && (m_lvl[i] == m_cap[i]);
        if (!act)          n_st[i] = 1'b0;
        else if (hit)      n_st[i] = 1'b1;
        else if (rd[i/LW]) n_st[i] = 1'b0;
        else if (ac)       n_st[i] = 1'b0;
        else               n_st[i] = m_st[i];
        if (rd[i/LW]) m_cap[i] = m_lvl[i];
        m_lvl[i] = m_flt[i];
        if (nr >= thr) m_flt[i] = pin[i];
        m_rawq[i] = pin[i];
        m_run[i]  = nr;
      end
    end
    m_st  = n_st;
    m_irq = |n_st;
  end

  task automatic check(input string req, input string what, input logic [N-1:0] act_v, input logic [N-1:0] exp_v);
    vectors++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act_v, exp_v, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 1) begin
      check(cur_req, "irq_status", st, m_st);
      check(cur_req, "deb_level", deb, m_lvl);
      check("R10", "irq_drive_low", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq});
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_lanes(input logic [NL-1:0] which);
    rd = which; tick(1); rd = '0;
  endtask

  task automatic wiggle(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      pin = pin ^ N'($urandom);
      if ((k % 4) == 3) rd = NL'($urandom);
      tick(1); rd = '0;
      tick(gap);
    end
  endtask

  initial begin
    pin = N'($urandom);
    tick(3);
    // R1: reset state
    check("R1", "status at reset", st, '0);
    check("R1", "level at reset", deb, pin);
    check("R1", "irq at reset", {{(N-1){1'b0}}, irq}, '0);
    rst = 1'b0;
    tick(2);

    // R2: outputs and disabled inputs stay quiet
    cur_req = "R2"; flt_on = '0;
    dir = '0; ien = '1; wiggle(20, 1);
    dir = '1; ien = '0; wiggle(20, 1);
    check("R2", "inactive status", st, '0);

    // R3: equal edge selects, both values
    cur_req = "R3"; ien = '1; ren = 16'hF0F0; fen = 16'hF0F0;
    read_lanes('1);
    pin[4] = ~pin[4]; tick(2);
    check("R3", "either-edge bit4", st & 16'h0010, 16'h0010);
    wiggle(30, 2);

    // R4: single-direction selects
    cur_req = "R4"; ren = 16'h00FF; fen = 16'hFF00;
    read_lanes('1); tick(1);
    pin[0] = 1'b0; pin[8] = 1'b1; tick(3); read_lanes('1); tick(1);
    pin[0] = 1'b1; pin[8] = 1'b0; tick(2);
    check("R4", "rise on 0, fall on 8", st & 16'h0101, 16'h0101);
    read_lanes('1);
    pin[0] = 1'b0; pin[8] = 1'b1; tick(3);
    check("R4", "wrong direction ignored", st & 16'h0101, 16'h0000);
    wiggle(30, 2);

    // R5: persistence filter
    cur_req = "R5"; flt_on = '1; ren = '0; fen = '0;
    tick(FC + 2); read_lanes('1); tick(1);
    pin[2] = ~pin[2]; tick(FC - 1); pin[2] = ~pin[2]; tick(FC + 3);
    check("R5", "short pulse rejected", st & 16'h0004, 16'h0000);
    pin[2] = ~pin[2]; tick(FC + 3);
    check("R5", "long level accepted", st & 16'h0004, 16'h0004);
    wiggle(20, FC / 2);
    wiggle(20, FC + 1);

    // R6: unfiltered timing
    cur_req = "R6"; flt_on = '0; ren = '1; fen = '1;
    tick(2); read_lanes('1); tick(1);
    pin[9] = ~pin[9]; tick(1);
    check("R6", "not yet set", st & 16'h0200, 16'h0000);
    tick(1);
    check("R6", "set after second edge", st & 16'h0200, 16'h0200);

    // R7: lane-local read clear
    cur_req = "R7";
    pin[1] = ~pin[1]; tick(3);
    read_lanes(2'b01); tick(1);
    check("R7", "lane0 cleared, lane1 kept", st & 16'h0202, 16'h0200);

    // R8: return-to-captured clear
    cur_req = "R8"; ren = '0; fen = '0; read_lanes('1); tick(1);
    pin[5] = ~pin[5]; tick(3);
    check("R8", "pending after change", st & 16'h0020, 16'h0020);
    pin[5] = ~pin[5]; tick(4);
    check("R8", "self-cleared on return", st & 16'h0020, 16'h0000);

    // R9: edge and read on the same edge
    cur_req = "R9"; ren = '1; fen = '1; read_lanes('1); tick(1);
    pin[12] = ~pin[12]; tick(1);
    rd = 2'b10; tick(1); rd = '0;
    check("R9", "edge beats read", st & 16'h1000, 16'h1000);

    // mixed random run
    cur_req = "R7";
    for (int k = 0; k < 60; k++) begin
      dir = N'($urandom) | 16'h5A5A; ien = N'($urandom) | 16'h3C3C;
      ren = N'($urandom); fen = N'($urandom); flt_on = N'($urandom);
      wiggle(8, k % 3);
      if (k % 9 == 0) read_lanes('1);
    end

    tick(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule